// File: doc/BRIEF.md
# 8-bit ALU with Eight-Flag Status Register

This block is the arithmetic-logic stage of a small 8-bit RISC core. Each cycle it takes two 8-bit operands, an operation code and a select that replaces the second operand with an immediate byte. It then produces the 8-bit result and the next value of an eight-bit status byte, both combinationally. The status byte itself lives in a register inside the block. That register loads the new flags on every clock edge where the execute strobe is high. The current flags feed back into the carry-in of the carry-chained operations and into the flags that an operation leaves unchanged.

The operation set covers the following:
- additions and subtractions, each with and without carry;
- compares, with and without carry;
- the three bitwise logic operations;
- one's and two's complement, increment and decrement;
- logical and arithmetic shifts, and rotates through carry;
- a nibble swap;
- single-flag set and clear.

Every operation writes its own set of flags and leaves the others unchanged. The signed-test flag S is kept equal to N xor V. This lets a later branch unit use S for signed comparisons. Compare-with-carry and subtract-with-carry only ever clear Z, so a multi-byte compare leaves Z set only when every byte was equal.

Top module: `alu8_status`

## Requirements
- R1: An active-low reset clears all eight status bits to 0, asynchronously. Status bit positions from bit 7 down to bit 0 are: interrupt-enable, T, H (half carry), S (signed), V (overflow), N (negative), Z (zero), C (carry).
- R2: Opcodes 0 (add) and 1 (add with carry-in C) give result = A + B (+ C). They set C to the carry out of bit 7 and H to the carry out of bit 3. V is set on signed overflow, N = result bit 7, Z = (result == 0).
- R3: Opcodes 2 (subtract) and 4 (compare) give result = A − B. They set C to the borrow out of bit 7 and H to the borrow into bit 4. V is set on signed overflow, and N and Z are taken from the result. A compare drives the difference on `result` like a subtract.
- R4: Opcodes 3 (subtract with borrow C) and 5 (compare with borrow C) give result = A − B − C and update C, H, V and N as in R3. Z stays at its old value when the result is zero and is cleared otherwise.
- R5: Opcodes 6 (AND), 7 (OR) and 8 (XOR) update Z and N from the result and clear V. C and H keep their values.
- R6: Opcode 9 (one's complement) gives 0xFF − A, sets C to 1 and clears V, and leaves H unchanged. Opcode 10 (negate) gives 0x00 − A and sets C, H, V, N and Z as a subtraction of A from zero.
- R7: Opcodes 11 (increment) and 12 (decrement) set V only on the 0x7F→0x80 and 0x80→0x7F transitions respectively. They update Z and N, and leave C and H unchanged.
- R8: Opcodes 13 (logical left shift), 14 (logical right shift), 15 (rotate left through C), 16 (rotate right through C) and 17 (arithmetic right shift, bit 7 kept) load C with the bit shifted out. They set N and Z from the result and V = N xor C. H is left unchanged.
- R9: Opcode 18 swaps result bits 7..4 with 3..0 and leaves every status bit unchanged.
- R10: Opcodes 19 (set flag) and 20 (clear flag) write 1 or 0 to the status bit indexed by bits 2..0 of the second operand and leave the other seven bits unchanged. `result` passes A. Opcodes 0 to 18 never change bits 7 and 6.
- R11: While `exec` is low the status register holds its value; `flags_nxt` still shows the flags the operation would produce.
- R12: With `imm_sel` high the immediate byte replaces B as the second operand for every opcode.
- R13: Every opcode from 0 to 17 leaves S equal to N xor V after the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Load `flags_nxt` into the status register at the clock edge |
| op | input | 5 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| imm | input | 8 | Immediate second operand |
| imm_sel | input | 1 | Select `imm` instead of `b` |
| result | output | 8 | Combinational result |
| flags_nxt | output | 8 | Combinational next status byte |
| status | output | 8 | Registered status byte |

## Verification
A wrong value in the status register cannot stay hidden. It shows on `status` at the very next sampling point, and it also changes the carry-in or the preserved flags of the next operation, so `result` or `flags_nxt` drifts within one further cycle. Each vector therefore first loads a known status byte through the set and clear opcodes, and only then applies the operation. The bench compares the combinational outputs before the edge and the stored byte after it. This catches both wrong flag logic and a faulty write gate within a single operation.

// File: rtl/alu8_status.sv
module alu8_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [4:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [7:0] imm,
  input  logic       imm_sel,
  output logic [7:0] result,
  output logic [7:0] flags_nxt,
  output logic [7:0] status
);
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11;
  localparam logic [4:0] OP_DEC = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15;
  localparam logic [4:0] OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWP = 5'd18, OP_FST = 5'd19;
  localparam logic [4:0] OP_FCL = 5'd20;

  logic [7:0] opb;
  logic       cin;
  logic       use_c;
  logic       chain;
  logic [8:0] t9;

  assign opb   = imm_sel ? imm : b;
  assign cin   = status[FC];
  assign use_c = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
  assign chain = (op == OP_SBC) || (op == OP_CPC);

  function automatic logic [7:0] add_fl(input logic [7:0] st, input logic [7:0] x,
                                        input logic [7:0] y, input logic [7:0] r,
                                        input logic co);
    logic [7:0] f;
    f     = st;
    f[FC] = co;
    f[FH] = (x[3] & y[3]) | (y[3] & ~r[3]) | (~r[3] & x[3]);
    f[FV] = (x[7] & y[7] & ~r[7]) | (~x[7] & ~y[7] & r[7]);
    f[FN] = r[7];
    f[FZ] = (r == 8'h00);
    f[FS] = f[FN] ^ f[FV];
    return f;
  endfunction

  function automatic logic [7:0] sub_fl(input logic [7:0] st, input logic [7:0] x,
                                        input logic [7:0] y, input logic [7:0] r,
                                        input logic ch);
    logic [7:0] f;
    f     = st;
    f[FC] = (~x[7] & y[7]) | (y[7] & r[7]) | (r[7] & ~x[7]);
    f[FH] = (~x[3] & y[3]) | (y[3] & r[3]) | (r[3] & ~x[3]);
    f[FV] = (x[7] & ~y[7] & ~r[7]) | (~x[7] & y[7] & r[7]);
    f[FN] = r[7];
    f[FZ] = ch ? ((r == 8'h00) & st[FZ]) : (r == 8'h00);
    f[FS] = f[FN] ^ f[FV];
    return f;
  endfunction

  function automatic logic [7:0] nzv_fl(input logic [7:0] st, input logic [7:0] r,
                                        input logic v);
    logic [7:0] f;
    f     = st;
    f[FV] = v;
    f[FN] = r[7];
    f[FZ] = (r == 8'h00);
    f[FS] = r[7] ^ v;
    return f;
  endfunction

  function automatic logic [7:0] sh_fl(input logic [7:0] st, input logic [7:0] r,
                                       input logic co);
    logic [7:0] f;
    f     = st;
    f[FC] = co;
    f[FN] = r[7];
    f[FZ] = (r == 8'h00);
    f[FV] = r[7] ^ co;
    f[FS] = f[FN] ^ f[FV];
    return f;
  endfunction

  always_comb begin
    result    = a;
    flags_nxt = status;
    t9        = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        t9        = {1'b0, a} + {1'b0, opb} + {8'd0, use_c & cin};
        result    = t9[7:0];
        flags_nxt = add_fl(status, a, opb, t9[7:0], t9[8]);
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CPC: begin
        t9        = {1'b0, a} - {1'b0, opb} - {8'd0, use_c & cin};
        result    = t9[7:0];
        flags_nxt = sub_fl(status, a, opb, t9[7:0], chain);
      end
      OP_NEG: begin
        result    = 8'h00 - a;
        flags_nxt = sub_fl(status, 8'h00, a, result, 1'b0);
      end
      OP_AND: begin
        result    = a & opb;
        flags_nxt = nzv_fl(status, result, 1'b0);
      end
      OP_OR: begin
        result    = a | opb;
        flags_nxt = nzv_fl(status, result, 1'b0);
      end
      OP_XOR: begin
        result    = a ^ opb;
        flags_nxt = nzv_fl(status, result, 1'b0);
      end
      OP_COM: begin
        result        = ~a;
        flags_nxt     = nzv_fl(status, result, 1'b0);
        flags_nxt[FC] = 1'b1;
      end
      OP_INC: begin
        result    = a + 8'd1;
        flags_nxt = nzv_fl(status, result, result == 8'h80);
      end
      OP_DEC: begin
        result    = a - 8'd1;
        flags_nxt = nzv_fl(status, result, result == 8'h7F);
      end
      OP_LSL: begin
        result    = {a[6:0], 1'b0};
        flags_nxt = sh_fl(status, result, a[7]);
      end
      OP_LSR: begin
        result    = {1'b0, a[7:1]};
        flags_nxt = sh_fl(status, result, a[0]);
      end
      OP_ROL: begin
        result    = {a[6:0], cin};
        flags_nxt = sh_fl(status, result, a[7]);
      end
      OP_ROR: begin
        result    = {cin, a[7:1]};
        flags_nxt = sh_fl(status, result, a[0]);
      end
      OP_ASR: begin
        result    = {a[7], a[7:1]};
        flags_nxt = sh_fl(status, result, a[0]);
      end
      OP_SWP: result = {a[3:0], a[7:4]};
      OP_FST: flags_nxt[opb[2:0]] = 1'b1;
      OP_FCL: flags_nxt[opb[2:0]] = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status <= 8'h00;
    else if (exec) status <= flags_nxt;
  end
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec,
  input logic [4:0] op,
  input logic [7:0] a,
  input logic [7:0] result,
  input logic [7:0] status
);
  p_swap_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 5'd18) |=> status == $past(status));

  p_swap_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd18) |-> result == {a[3:0], a[7:4]});

  p_logic_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op >= 5'd6 && op <= 5'd8) |=>
      (!status[3] && status[0] == $past(status[0]) && status[5] == $past(status[5])));

  p_com_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 5'd9) |=> status[0]);

  p_chain_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == 5'd3 || op == 5'd5) && !status[1]) |=> !status[1]);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> status == $past(status));

  p_sign_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op <= 5'd17) |=> status[4] == (status[3] ^ status[2]));

  p_upper_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op <= 5'd18) |=> status[7:6] == $past(status[7:6]));
endmodule

bind alu8_status alu8_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec(exec), .op(op),
  .a(a), .result(result), .status(status)
);

// File: tb/alu8_status_bench.sv
module alu8_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  logic [7:0] imm = '0;
  logic       imm_sel = 1'b0;
  logic [7:0] result;
  logic [7:0] flags_nxt;
  logic [7:0] status;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  alu8_status u_alu8_status (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .a(a), .b(b),
    .imm(imm), .imm_sel(imm_sel), .result(result), .flags_nxt(flags_nxt),
    .status(status)
  );

  always #10 clk = ~clk;

  localparam int NV = 33;
  // {op, a, b, preset status, expected result, expected status}
  localparam logic [44:0] VEC [NV] = '{
    {5'd0,  8'h7F, 8'h01, 8'h00, 8'h80, 8'h2C},
    {5'd0,  8'hFF, 8'h01, 8'h00, 8'h00, 8'h23},
    {5'd1,  8'h10, 8'h20, 8'hC1, 8'h31, 8'hC0},
    {5'd2,  8'h10, 8'h01, 8'h00, 8'h0F, 8'h20},
    {5'd2,  8'h80, 8'h01, 8'h00, 8'h7F, 8'h38},
    {5'd2,  8'h00, 8'h01, 8'h00, 8'hFF, 8'h35},
    {5'd3,  8'h05, 8'h05, 8'h03, 8'hFF, 8'h35},
    {5'd3,  8'h05, 8'h05, 8'h02, 8'h00, 8'h02},
    {5'd3,  8'h05, 8'h05, 8'h00, 8'h00, 8'h00},
    {5'd4,  8'h40, 8'h40, 8'h00, 8'h00, 8'h02},
    {5'd5,  8'h12, 8'h11, 8'h03, 8'h00, 8'h02},
    {5'd5,  8'h12, 8'h11, 8'h01, 8'h00, 8'h00},
    {5'd6,  8'hF0, 8'h8F, 8'h29, 8'h80, 8'h35},
    {5'd7,  8'h00, 8'h00, 8'h08, 8'h00, 8'h02},
    {5'd8,  8'hAA, 8'h55, 8'h00, 8'hFF, 8'h14},
    {5'd9,  8'h55, 8'h00, 8'h00, 8'hAA, 8'h15},
    {5'd9,  8'hFF, 8'h00, 8'h20, 8'h00, 8'h23},
    {5'd10, 8'h01, 8'h00, 8'h00, 8'hFF, 8'h35},
    {5'd10, 8'h80, 8'h00, 8'h00, 8'h80, 8'h0D},
    {5'd10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02},
    {5'd11, 8'h7F, 8'h00, 8'h21, 8'h80, 8'h2D},
    {5'd11, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h02},
    {5'd12, 8'h80, 8'h00, 8'h00, 8'h7F, 8'h18},
    {5'd12, 8'h01, 8'h00, 8'h00, 8'h00, 8'h02},
    {5'd13, 8'h81, 8'h00, 8'h20, 8'h02, 8'h39},
    {5'd14, 8'h01, 8'h00, 8'h00, 8'h00, 8'h1B},
    {5'd15, 8'h40, 8'h00, 8'h01, 8'h81, 8'h0C},
    {5'd16, 8'h02, 8'h00, 8'h01, 8'h81, 8'h0C},
    {5'd17, 8'h81, 8'h00, 8'h00, 8'hC0, 8'h15},
    {5'd18, 8'h3C, 8'h00, 8'hA5, 8'hC3, 8'hA5},
    {5'd19, 8'h12, 8'h07, 8'h00, 8'h12, 8'h80},
    {5'd20, 8'h34, 8'h04, 8'hFF, 8'h34, 8'hEF},
    {5'd19, 8'h00, 8'h0E, 8'h00, 8'h00, 8'h40}
  };

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd1:                       return "R2";
      5'd2, 5'd4:                       return "R3";
      5'd3, 5'd5:                       return "R4";
      5'd6, 5'd7, 5'd8:                 return "R5";
      5'd9, 5'd10:                      return "R6";
      5'd11, 5'd12:                     return "R7";
      5'd13, 5'd14, 5'd15, 5'd16, 5'd17: return "R8";
      5'd18:                            return "R9";
      default:                          return "R10";
    endcase
  endfunction

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic run(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                     output logic [7:0] r, output logic [7:0] fn);
    @(negedge clk);
    op = o; a = x; b = y; exec = 1'b1;
    #5;
    r  = result;
    fn = flags_nxt;
    @(negedge clk);
    exec = 1'b0;
  endtask

  task automatic preset(input logic [7:0] s);
    logic [7:0] r, fn;
    for (int i = 0; i < 8; i++)
      run(s[i] ? 5'd19 : 5'd20, 8'h00, 8'(i), r, fn);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, fn;
    logic [44:0] v;
    repeat (3) @(negedge clk);
    check("R1 status after reset", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status held after release", status, 8'h00);

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      preset(v[23:16]);
      run(v[44:40], v[39:32], v[31:24], r, fn);
      check($sformatf("%s vec %0d result", tag_of(v[44:40]), k), r, v[15:8]);
      check($sformatf("%s vec %0d flags_nxt", tag_of(v[44:40]), k), fn, v[7:0]);
      check($sformatf("%s vec %0d status", tag_of(v[44:40]), k), status, v[7:0]);
      if (v[44:40] <= 5'd17)
        check($sformatf("R13 vec %0d S bit", k), {7'd0, status[4]},
              {7'd0, status[3] ^ status[2]});
    end

    // R11: no store while exec is low
    preset(8'h00);
    @(negedge clk);
    op = 5'd0; a = 8'hFF; b = 8'h01; exec = 1'b0;
    #5;
    check("R11 flags_nxt while idle", flags_nxt, 8'h23);
    @(negedge clk);
    check("R11 status held while idle", status, 8'h00);

    // R12: immediate replaces b
    imm = 8'h05; imm_sel = 1'b1;
    run(5'd0, 8'h10, 8'hFF, r, fn);
    check("R12 immediate add result", r, 8'h15);
    check("R12 immediate add status", status, 8'h00);
    run(5'd19, 8'h00, 8'h00, r, fn);
    check("R12 immediate flag index", status, 8'h20);
    imm_sel = 1'b0;

    // R4: two-byte compare 0x1234 vs 0x1234, then 0x1234 vs 0x1334
    preset(8'h00);
    run(5'd4, 8'h34, 8'h34, r, fn);
    run(5'd5, 8'h12, 8'h12, r, fn);
    check("R4 chained equal compare", status, 8'h02);
    run(5'd4, 8'h34, 8'h34, r, fn);
    run(5'd5, 8'h12, 8'h13, r, fn);
    check("R4 chained unequal compare", status, 8'h35);

    // R1: asynchronous reset mid-run
    preset(8'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    check("R1 async clear", status, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule